// File: doc/BRIEF.md
# Open-Page DRAM Read Command Sequencer

The sequencer takes one read request at a time. Each request names a bank, a row and a column. From it the sequencer builds a short stream of DRAM commands: row close, row open and column read. It keeps the open row of each of four banks and leaves a row open after it is used, so the cost of a request depends on what that bank already holds.

- **Hit.** A request that finds its row already open gets a column read at once.
- **Closed bank.** A request to a bank with no open row starts with a row open.
- **Miss.** A request that finds another row open closes it first. The close waits until the row has been open for the minimum active time.

Four runtime inputs, each in clock cycles from 1 to 15, set the spacing between commands. They must stay stable while requests or bursts are in flight. After each column read the block raises a data-valid strobe during the cycles in which a 64-bit data beat is due, as a burst of 4 or 8 beats.

The controller is a four-state machine:

- **S_IDLE** waits for a request. It has three exits: accept-closed goes to S_ACT, accept-hit goes to S_RD, and accept-miss goes to S_PRE.
- **S_PRE** waits for its spacing counter and for the bank's minimum-active timer. The transition pre-fire goes to S_ACT.
- **S_ACT** waits for the close-to-open spacing. The transition act-fire goes to S_RD.
- **S_RD** waits for the open-to-read spacing. The transition rd-fire goes back to S_IDLE.

Top module: `dram_seq_top`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, `cmd` is NOP and `rd_valid` is 0. All banks are closed, so the first request to any bank opens a row without a close command.
- R2: `req_ready` falls in the cycle after a request is accepted and stays 0 until the column read for that request is on `cmd`. It is 1 again in the following cycle.
- R3: For a request to a closed bank, the row-open command is issued in the cycle after acceptance. The column read follows exactly `cfg_rcd` cycles after the row-open command.
- R4: For a request whose row is already open in its bank, the column read is issued in the cycle after acceptance, with no close or open command.
- R5: For a request whose bank has a different row open, the close command comes first. The row open follows exactly `cfg_rp` cycles later, and the column read follows `cfg_rcd` cycles after the row open.
- R6: A close command for a bank is issued no earlier than `cfg_ras` cycles after that bank's last row-open command. When the request arrives earlier, the close is issued in the first cycle this allows; otherwise it is issued in the cycle after acceptance.
- R7: Each bank keeps its own open row. Commands to other banks do not close it or change it.
- R8: `cmd` uses the codes NOP=0, close=1, open=2 and read=3, and carries at most one command per cycle. On a row-open command `cmd_addr` holds the row. On a read command it holds the column, zero-extended. `cmd_bank` holds the target bank.
- R9: `rd_valid` is 1 for exactly 4 beats (`cfg_burst8`=0) or 8 beats (`cfg_burst8`=1), starting `cfg_cl` cycles after each read command. When bursts overlap, the strobe covers the union of their windows.
- R10: `cmd` is NOP in every cycle in which no command is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_bank | input | 2 | Request bank |
| req_row | input | 13 | Request row |
| req_col | input | 10 | Request column |
| cfg_rp | input | 4 | Close-to-open spacing, cycles |
| cfg_rcd | input | 4 | Open-to-read spacing, cycles |
| cfg_cl | input | 4 | Read-to-data latency, cycles |
| cfg_ras | input | 4 | Minimum row-open time, cycles |
| cfg_burst8 | input | 1 | 1 selects 8 beats per burst, 0 selects 4 |
| cmd | output | 2 | Command code |
| cmd_bank | output | 2 | Command bank |
| cmd_addr | output | 13 | Row or column of the command |
| rd_valid | output | 1 | Data beat expected this cycle |

## Verification
The bench builds the block with its default widths: four banks, 4-bit timing fields, 13-bit rows and 10-bit columns. It sweeps each of the four timing inputs over the values 1, 3 and 15, with both burst lengths, which makes 162 configurations. Each configuration starts from reset and runs a fixed request script. The script covers:

- closed-bank opens on all four banks;
- hits;
- misses that arrive inside the minimum-active window and must stall, and misses that arrive after it;
- work on a neighbouring bank, to show that other banks' rows survive.

Because the reads come only a few cycles apart, bursts overlap whenever the latency or burst length allows it. Expected command cycles and data-valid windows come from arithmetic on the timing values and the cycle of each acceptance.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_ACT = 2'd2,
        CMD_RD  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PRE  = 2'd1,
        S_ACT  = 2'd2,
        S_RD   = 2'd3
    } state_e;

endpackage

// File: rtl/dram_bank_slot.sv
module dram_bank_slot #(
    parameter int ROW_W = 13,
    parameter int TW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_en,
    input  logic             pre_en,
    input  logic [ROW_W-1:0] row_in,
    input  logic [TW-1:0]    tras,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             ras_done
);

    logic [TW-1:0] ras_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            open_row <= '0;
            ras_cnt  <= '0;
        end else begin
            if (act_en) begin
                is_open  <= 1'b1;
                open_row <= row_in;
                ras_cnt  <= (tras == '0) ? '0 : tras - 1'b1;
            end else begin
                if (pre_en) begin
                    is_open <= 1'b0;
                end
                if (ras_cnt != '0) begin
                    ras_cnt <= ras_cnt - 1'b1;
                end
            end
        end
    end

    assign ras_done = (ras_cnt == '0);

    // Cycles since the last row open, saturating; used only by the checks below.
    logic [TW-1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '1;
        end else if (act_en) begin
            age_q <= {{(TW-1){1'b0}}, 1'b1};
        end else if (age_q != '1) begin
            age_q <= age_q + 1'b1;
        end
    end

    p_pre_after_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> (age_q >= tras));

    p_pre_only_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> is_open);

    p_act_only_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |-> !is_open);

endmodule

// File: rtl/dram_burst_timer.sv
module dram_burst_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_fire,
    input  logic [TW-1:0] cl,
    input  logic          bl8,
    output logic          rd_valid
);

    localparam int HIST = (1 << TW) - 1;

    logic [HIST-1:0] hist;
    logic [3:0]      rem;
    logic            start;
    logic [TW-1:0]   tap;

    // hist[k] set means a read command was issued k+1 cycles ago.
    assign tap   = (cl == '0) ? '0 : cl - 1'b1;
    assign start = hist[tap];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
            rem  <= '0;
        end else begin
            hist <= {hist[HIST-2:0], rd_fire};
            if (start) begin
                rem <= bl8 ? 4'd7 : 4'd3;
            end else if (rem != '0) begin
                rem <= rem - 1'b1;
            end
        end
    end

    assign rd_valid = start || (rem != '0);

endmodule

// File: rtl/dram_seq_top.sv
module dram_seq_top
    import dram_seq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int TW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [TW-1:0]     cfg_rp,
    input  logic [TW-1:0]     cfg_rcd,
    input  logic [TW-1:0]     cfg_cl,
    input  logic [TW-1:0]     cfg_ras,
    input  logic              cfg_burst8,
    output logic [1:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic              rd_valid
);

    localparam int NB = 1 << BANK_W;

    state_e            state, state_nx;
    logic [BANK_W-1:0] cur_bank;
    logic [ROW_W-1:0]  cur_row;
    logic [COL_W-1:0]  cur_col;
    logic [TW-1:0]     gap;

    logic [NB-1:0]     open_vec;
    logic [NB-1:0]     ras_done_vec;
    logic [ROW_W-1:0]  row_arr [NB];
    logic [NB-1:0]     act_vec;
    logic [NB-1:0]     pre_vec;

    logic accept, pre_fire, act_fire, rd_fire;
    cmd_e cmd_e_w;

    assign accept   = req_valid && (state == S_IDLE);
    assign pre_fire = (state == S_PRE) && (gap == '0) && ras_done_vec[cur_bank];
    assign act_fire = (state == S_ACT) && (gap == '0);
    assign rd_fire  = (state == S_RD)  && (gap == '0);

    // Per-bank open-row tracking
    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign act_vec[b] = act_fire && (cur_bank == b[BANK_W-1:0]);
        assign pre_vec[b] = pre_fire && (cur_bank == b[BANK_W-1:0]);

        dram_bank_slot #(.ROW_W(ROW_W), .TW(TW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_en   (act_vec[b]),
            .pre_en   (pre_vec[b]),
            .row_in   (cur_row),
            .tras     (cfg_ras),
            .is_open  (open_vec[b]),
            .open_row (row_arr[b]),
            .ras_done (ras_done_vec[b])
        );
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    if (!open_vec[req_bank])                 state_nx = S_ACT;
                    else if (row_arr[req_bank] == req_row)   state_nx = S_RD;
                    else                                     state_nx = S_PRE;
                end
            end
            S_PRE:  if (pre_fire) state_nx = S_ACT;
            S_ACT:  if (act_fire) state_nx = S_RD;
            S_RD:   if (rd_fire)  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Request capture and spacing counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_bank <= '0;
            cur_row  <= '0;
            cur_col  <= '0;
            gap      <= '0;
        end else begin
            if (accept) begin
                cur_bank <= req_bank;
                cur_row  <= req_row;
                cur_col  <= req_col;
                gap      <= '0;
            end else if (pre_fire) begin
                gap <= (cfg_rp == '0) ? '0 : cfg_rp - 1'b1;
            end else if (act_fire) begin
                gap <= (cfg_rcd == '0) ? '0 : cfg_rcd - 1'b1;
            end else if (gap != '0) begin
                gap <= gap - 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        cmd_e_w  = CMD_NOP;
        cmd_bank = '0;
        cmd_addr = '0;
        unique case (state)
            S_IDLE: ;
            S_PRE: if (pre_fire) begin
                cmd_e_w  = CMD_PRE;
                cmd_bank = cur_bank;
            end
            S_ACT: if (act_fire) begin
                cmd_e_w  = CMD_ACT;
                cmd_bank = cur_bank;
                cmd_addr = cur_row;
            end
            S_RD: if (rd_fire) begin
                cmd_e_w  = CMD_RD;
                cmd_bank = cur_bank;
                cmd_addr = {{(ROW_W-COL_W){1'b0}}, cur_col};
            end
            default: ;
        endcase
    end

    assign cmd       = cmd_e_w;
    assign req_ready = (state == S_IDLE);

    dram_burst_timer #(.TW(TW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fire  (rd_fire),
        .cl       (cfg_cl),
        .bl8      (cfg_burst8),
        .rd_valid (rd_valid)
    );

    // Last command and the cycles since it, for the spacing checks below.
    logic [1:0] last_cmd_q;
    logic [4:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cmd_q <= CMD_NOP;
            since_q    <= '1;
        end else if (cmd != CMD_NOP) begin
            last_cmd_q <= cmd;
            since_q    <= 5'd1;
        end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    p_act_after_rp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && last_cmd_q == CMD_PRE) |-> (since_q == {1'b0, cfg_rp}));

    p_rd_after_rcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD && last_cmd_q == CMD_ACT) |-> (since_q == {1'b0, cfg_rcd}));

    p_rd_row_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD) |-> (open_vec[cmd_bank] && row_arr[cmd_bank] == cur_row));

    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_ready_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD) |=> req_ready);

endmodule

// File: tb/dram_seq_top_tb.sv
module dram_seq_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_bank;
    logic [12:0] req_row;
    logic [9:0]  req_col;
    logic [3:0]  cfg_rp, cfg_rcd, cfg_cl, cfg_ras;
    logic        cfg_burst8;
    logic [1:0]  cmd;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr;
    logic        rd_valid;

    always #4 clk = ~clk;   // 125 MHz

    dram_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .cfg_rp(cfg_rp), .cfg_rcd(cfg_rcd), .cfg_cl(cfg_cl), .cfg_ras(cfg_ras),
        .cfg_burst8(cfg_burst8), .cmd(cmd), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .rd_valid(rd_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // Bench model of bank state
    bit m_open [4];
    int m_row  [4];
    int m_act  [4];

    // Expected data-valid ring, indexed by cycle modulo 64
    bit ring [64];
    bit ring_on = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Data-valid window check, every cycle (R9)
    always @(negedge clk) begin
        if (ring_on) begin
            check(rd_valid == ring[cyc % 64], "R9 rd_valid", rd_valid, ring[cyc % 64]);
            ring[cyc % 64] = 0;
        end
    end

    task automatic do_reset();
        ring_on = 0;
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && cmd == 2'd0 && rd_valid == 1'b0, "R1 reset outputs",
              {req_ready, cmd, rd_valid}, 4'b1000);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) ring[i] = 0;
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 0; m_row[i] = 0; m_act[i] = -100;
        end
        @(negedge clk);
        check(req_ready == 1'b1 && cmd == 2'd0, "R1 after reset", {req_ready, cmd}, 3'b100);
        ring_on = 1;
    endtask

    task automatic do_req(input int b, input int row, input int col);
        int acc, pre_c, act_c, rd_c, ecmd, eaddr, tmp;
        string tag;
        check(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
        check(cmd == 2'd0, "R10 idle NOP", cmd, 0);
        req_valid = 1'b1;
        req_bank  = b[1:0];
        req_row   = row[12:0];
        req_col   = col[9:0];
        acc   = cyc;
        pre_c = -1;
        act_c = -1;
        if (!m_open[b]) begin
            tag   = "R3 closed bank";
            act_c = acc + 1;
            rd_c  = act_c + int'(cfg_rcd);
        end else if (m_row[b] == row) begin
            tag  = "R4 hit";
            rd_c = acc + 1;
        end else begin
            tag   = "R5/R6 miss";
            tmp   = m_act[b] + int'(cfg_ras);
            pre_c = (acc + 1 > tmp) ? acc + 1 : tmp;
            act_c = pre_c + int'(cfg_rp);
            rd_c  = act_c + int'(cfg_rcd);
        end
        @(negedge clk);
        req_valid = 1'b0;
        while (cyc <= rd_c) begin
            if (cyc > acc + 200) begin
                check(0, "watchdog request", cyc, rd_c);
                return;
            end
            if (cyc == pre_c)      begin ecmd = 1; eaddr = -1;  end
            else if (cyc == act_c) begin ecmd = 2; eaddr = row; end
            else if (cyc == rd_c)  begin ecmd = 3; eaddr = col; end
            else                   begin ecmd = 0; eaddr = -1;  end
            check(int'(cmd) == ecmd, {tag, " R8/R10 cmd"}, cmd, ecmd);
            if (ecmd != 0)
                check(int'(cmd_bank) == b, "R8 cmd_bank", cmd_bank, b);
            if (eaddr >= 0)
                check(int'(cmd_addr) == eaddr, "R8 cmd_addr", cmd_addr, eaddr);
            if (cyc < rd_c)
                check(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
            if (cyc == rd_c) begin
                for (int i = 0; i < (cfg_burst8 ? 8 : 4); i++)
                    ring[(rd_c + int'(cfg_cl) + i) % 64] = 1;
            end
            @(negedge clk);
        end
        if (act_c >= 0) begin
            m_open[b] = 1;
            m_row[b]  = row;
            m_act[b]  = act_c;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_bank = '0; req_row = '0; req_col = '0;
        cfg_rp = 4'd1; cfg_rcd = 4'd1; cfg_cl = 4'd1; cfg_ras = 4'd1; cfg_burst8 = 1'b0;
        @(negedge clk);
        for (int bl = 0; bl < 2; bl++)
        for (int a = 0; a < 3; a++)
        for (int c = 0; c < 3; c++)
        for (int d = 0; d < 3; d++)
        for (int e = 0; e < 3; e++) begin
            cfg_rp     = (a == 0) ? 4'd1 : (a == 1) ? 4'd3 : 4'd15;
            cfg_rcd    = (c == 0) ? 4'd1 : (c == 1) ? 4'd3 : 4'd15;
            cfg_cl     = (d == 0) ? 4'd1 : (d == 1) ? 4'd3 : 4'd15;
            cfg_ras    = (e == 0) ? 4'd1 : (e == 1) ? 4'd3 : 4'd15;
            cfg_burst8 = bl[0];
            do_reset();
            do_req(0, 5, 1);      // R1/R3: first access opens without close
            do_req(0, 5, 2);      // R4 hit
            do_req(0, 9, 3);      // R5/R6 quick miss, may stall on min-active
            do_req(1, 9, 4);      // R3 other bank
            do_req(0, 9, 5);      // R7 bank 0 row kept
            do_req(1, 2, 6);      // R5 miss on bank 1
            do_req(2, 3, 7);
            do_req(3, 4, 8);
            do_req(2, 3, 1023);   // R4 hit, widest column
            repeat (20) @(negedge clk);
            do_req(0, 8191, 0);   // R6 miss long after open
            do_req(3, 4, 9);      // R7 bank 3 still open
            repeat (30) @(negedge clk);  // drain bursts (R9)
        end
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule